// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns digitized supply-monitor flags into the reset outputs of a supply supervisor. A primary-supply-low flag, a secondary-supply-low flag and an active-low push-button arrive on the system clock. A millisecond tick comes from an external timebase. The block drives a pair of complementary reset outputs, an early low-supply warning and a secondary-fail indication.

Reset is held through power-up and through any primary brownout. It is also held while the debounced button is pressed. Reset is let go only after a release window with no such cause present. The window is 150 ms or 800 ms, chosen by one select input. The warning output tracks the primary flag without any window. Reset assertion on a brownout lags the warning by a parameterized number of clocks, so the warning leads reset.

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst_n` is low and until the release window first completes, `sys_rst_n_o` is 0 and `sys_rst_o` is 1. `warn_n_o` and `sec_fail_n_o` reset to 0.
- R2: With `long_delay_i` = 0, reset is released on the clock edge of the 150th `ms_tick_i` pulse counted after every hold cause has cleared. Reset is still asserted after the 149th pulse. A release only ever happens on an edge where `ms_tick_i` is 1.
- R3: With `long_delay_i` = 1, the release window is 800 tick pulses instead of 150.
- R4: `warn_n_o` equals the inverse of `pri_low_i` one clock later, in both directions, with no release window.
- R5: When `pri_low_i` rises, reset asserts LEAD_CLKS+1 clocks later (default 4+1), which is LEAD_CLKS clocks after `warn_n_o` falls. A `pri_low_i` pulse shorter than LEAD_CLKS clocks does not assert reset.
- R6: `sec_fail_n_o` equals the inverse of `sec_low_i` one clock later, with no power-up delay.
- R7: `btn_n_i` low is accepted only after it has differed from the filtered level for DEB_TICKS tick pulses (default 16). The edge of the accepting tick updates the filtered level, and reset asserts on the following clock. A shorter press is ignored.
- R8: After the filtered button returns high, reset stays asserted for the full release window, the same as after a supply fault.
- R9: A new primary fault during a release countdown restarts the countdown from zero.
- R10: `sys_rst_o` is always the inverse of `sys_rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_low_i | input | 1 | Primary supply below threshold (synchronous) |
| sec_low_i | input | 1 | Secondary supply below threshold (synchronous) |
| btn_n_i | input | 1 | Manual reset button, active low, raw |
| long_delay_i | input | 1 | 0: 150-tick release window, 1: 800-tick window |
| ms_tick_i | input | 1 | One-clock pulse per millisecond |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |
| warn_n_o | output | 1 | Early primary low-supply warning, active low |
| sec_fail_n_o | output | 1 | Secondary supply fail, active low |

## Verification
The hardest case to reach from the ports is a restart of the countdown partway through a release window. A brief fault that lands mid-window leaves the outputs looking the same as an uninterrupted countdown. The only difference is when the release finally comes. The stimulus counts ticks itself, injects a short brownout 100 ticks into a window, and then shows that reset is still held 149 ticks after the fault. A design that kept counting would already have released by then. Debounce rejection is reached the same way: a press held for one tick fewer than the filter needs is ended by a release, and the reset output stays released.

// File: rtl/supv_pkg.sv
// Package: shared constants and width helper for the reset sequencer.
// Assumes tick-based timing; all durations are counted in ms_tick pulses.
package supv_pkg;
    localparam int unsigned SHORT_TICKS_DEF = 150;
    localparam int unsigned LONG_TICKS_DEF  = 800;
    localparam int unsigned DEB_TICKS_DEF   = 16;
    localparam int unsigned LEAD_CLKS_DEF   = 4;

    // Width of a counter that must hold values 0..n.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/supv_lead_delay.sv
// Module: supv_lead_delay
// Raises fault_o once low_i has been sampled high on LEAD_CLKS consecutive
// clock edges, and drops it as soon as low_i is seen low again.
// Assumes low_i is synchronous to clk and LEAD_CLKS >= 1.
module supv_lead_delay
    import supv_pkg::*;
#(
    parameter int unsigned LEAD_CLKS = LEAD_CLKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    output logic fault_o
);
    localparam int unsigned W = cnt_w(LEAD_CLKS);
    localparam logic [W-1:0] LEAD_V = W'(LEAD_CLKS);

    logic [W-1:0] run_q;

    // Count consecutive low samples, saturating at the lead length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!low_i)
            run_q <= '0;
        else if (run_q != LEAD_V)
            run_q <= run_q + 1'b1;
    end

    assign fault_o = (run_q == LEAD_V);
endmodule

// File: rtl/supv_debounce.sv
// Module: supv_debounce
// Filters a raw button level. A new level is taken only after it has differed
// from the current filtered level on DEB_TICKS tick pulses with no reversal.
// Assumes level_i is synchronous; the filtered level resets to released (1).
module supv_debounce
    import supv_pkg::*;
#(
    parameter int unsigned DEB_TICKS = DEB_TICKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic level_i,
    output logic level_o
);
    localparam int unsigned W = cnt_w(DEB_TICKS);
    localparam logic [W-1:0] LAST_V = W'(DEB_TICKS - 1);

    logic [W-1:0] cnt_q;
    logic         level_q;

    // Count ticks of disagreement; accept the new level at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else if (level_i == level_q) begin
            cnt_q   <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST_V) begin
                level_q <= level_i;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/supv_release_timer.sv
// Module: supv_release_timer
// Holds reset while hold_i is high and releases it once the selected number
// of tick pulses has passed with hold_i low. Drives both polarities from
// separate flops. Assumes LONG_TICKS >= SHORT_TICKS >= 1.
module supv_release_timer
    import supv_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = SHORT_TICKS_DEF,
    parameter int unsigned LONG_TICKS  = LONG_TICKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic tick_i,
    input  logic long_sel_i,
    output logic rst_n_o,
    output logic rst_o
);
    localparam int unsigned W = cnt_w(LONG_TICKS);
    localparam logic [W-1:0] SHORT_M1 = W'(SHORT_TICKS - 1);
    localparam logic [W-1:0] LONG_M1  = W'(LONG_TICKS - 1);

    logic [W-1:0] cnt_q;
    logic         active_q;
    logic         active_d;
    logic [W-1:0] limit_m1;

    // Select the final count value for the current window.
    always_comb begin
        limit_m1 = long_sel_i ? LONG_M1 : SHORT_M1;
    end

    // Next reset state: hold wins, release on the tick that ends the window.
    always_comb begin
        active_d = active_q;
        if (hold_i)
            active_d = 1'b1;
        else if (active_q && tick_i && (cnt_q >= limit_m1))
            active_d = 1'b0;
    end

    // Window counter: cleared by any hold, and idle while released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold_i || !active_q)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Reset state and both output polarities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            rst_n_o  <= 1'b0;
            rst_o    <= 1'b1;
        end else begin
            active_q <= active_d;
            rst_n_o  <= ~active_d;
            rst_o    <= active_d;
        end
    end
endmodule

// File: rtl/supv_reset_seq.sv
// Module: supv_reset_seq (top)
// Builds the supervisor reset outputs from digitized supply flags, a button
// and a millisecond tick. Warning and secondary-fail outputs are registered
// copies of their flags; reset combines a lead-delayed primary fault with the
// debounced button and stretches release through the timer.
// Assumes every input is synchronous to clk.
module supv_reset_seq
    import supv_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = SHORT_TICKS_DEF,
    parameter int unsigned LONG_TICKS  = LONG_TICKS_DEF,
    parameter int unsigned DEB_TICKS   = DEB_TICKS_DEF,
    parameter int unsigned LEAD_CLKS   = LEAD_CLKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_low_i,
    input  logic sec_low_i,
    input  logic btn_n_i,
    input  logic long_delay_i,
    input  logic ms_tick_i,
    output logic sys_rst_n_o,
    output logic sys_rst_o,
    output logic warn_n_o,
    output logic sec_fail_n_o
);
    logic pri_fault;
    logic btn_level;
    logic hold;

    supv_lead_delay #(.LEAD_CLKS(LEAD_CLKS)) u_lead (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_i   (pri_low_i),
        .fault_o (pri_fault)
    );

    supv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (ms_tick_i),
        .level_i (btn_n_i),
        .level_o (btn_level)
    );

    assign hold = pri_fault | ~btn_level;

    supv_release_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .tick_i     (ms_tick_i),
        .long_sel_i (long_delay_i),
        .rst_n_o    (sys_rst_n_o),
        .rst_o      (sys_rst_o)
    );

    // Undelayed warning and secondary-fail flags, one register each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_n_o     <= 1'b0;
            sec_fail_n_o <= 1'b0;
        end else begin
            warn_n_o     <= ~pri_low_i;
            sec_fail_n_o <= ~sec_low_i;
        end
    end
endmodule

// File: rtl/supv_reset_chk.sv
// Module: supv_reset_chk
// Property checker for supv_reset_seq, attached by bind. Uses a counter of
// consecutive primary-low samples instead of a parameter-length delay.
module supv_reset_chk
    import supv_pkg::*;
#(
    parameter int unsigned LEAD_CLKS = LEAD_CLKS_DEF
) (
    input logic clk,
    input logic rst_n,
    input logic pri_low_i,
    input logic sec_low_i,
    input logic ms_tick_i,
    input logic sys_rst_n_o,
    input logic sys_rst_o,
    input logic warn_n_o,
    input logic sec_fail_n_o
);
    localparam int unsigned W = cnt_w(LEAD_CLKS);
    logic [W-1:0] low_run;

    // Count consecutive primary-low samples, saturating at the lead length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!pri_low_i)
            low_run <= '0;
        else if (low_run != W'(LEAD_CLKS))
            low_run <= low_run + 1'b1;
    end

    assert_polarity_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o == !sys_rst_n_o);

    assert_warn_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (warn_n_o == !$past(pri_low_i)));

    assert_sec_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sec_fail_n_o == !$past(sec_low_i)));

    assert_fault_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_low_i && (low_run == W'(LEAD_CLKS))) |=> !sys_rst_n_o);

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n_o) |-> $past(ms_tick_i));
endmodule

bind supv_reset_seq supv_reset_chk #(.LEAD_CLKS(LEAD_CLKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pri_low_i    (pri_low_i),
    .sec_low_i    (sec_low_i),
    .ms_tick_i    (ms_tick_i),
    .sys_rst_n_o  (sys_rst_n_o),
    .sys_rst_o    (sys_rst_o),
    .warn_n_o     (warn_n_o),
    .sec_fail_n_o (sec_fail_n_o)
);

// File: tb/tb_supv_reset_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected output values with the cycle
// they are due; a monitor compares them at falling edges.
module tb_supv_reset_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_low = 1'b0;
    logic sec_low = 1'b0;
    logic btn_n = 1'b1;
    logic long_sel = 1'b0;
    logic ms_tick = 1'b0;
    logic sys_rst_n, sys_rst, warn_n, sec_fail_n;

    typedef struct {
        int    due;
        int    sel;     // 0: reset pair, 1: warn_n, 2: sec_fail_n
        logic  val;
        string req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    supv_reset_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pri_low_i    (pri_low),
        .sec_low_i    (sec_low),
        .btn_n_i      (btn_n),
        .long_delay_i (long_sel),
        .ms_tick_i    (ms_tick),
        .sys_rst_n_o  (sys_rst_n),
        .sys_rst_o    (sys_rst),
        .warn_n_o     (warn_n),
        .sec_fail_n_o (sec_fail_n)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Queue an expectation k rising edges from now, kept in due order.
    task automatic expect_out(input int k, input int sel, input logic v, input string req);
        exp_t it;
        int   p;
        it = '{due: cyc + k, sel: sel, val: v, req: req};
        p = sb.size();
        while (p > 0 && sb[p-1].due > it.due) p--;
        sb.insert(p, it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // n tick pulses, each followed by one idle clock.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Monitor: compare every expectation that has come due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            n_vec++;
            case (it.sel)
                0: if (sys_rst_n !== it.val || sys_rst !== !it.val) begin
                       n_bad++;
                       $display("FAIL %s (R10 pair): rst_n=%b rst=%b expected rst_n=%b rst=%b",
                                it.req, sys_rst_n, sys_rst, it.val, !it.val);
                   end
                1: if (warn_n !== it.val) begin
                       n_bad++;
                       $display("FAIL %s: warn_n=%b expected %b", it.req, warn_n, it.val);
                   end
                default: if (sec_fail_n !== it.val) begin
                       n_bad++;
                       $display("FAIL %s: sec_fail_n=%b expected %b", it.req, sec_fail_n, it.val);
                   end
            endcase
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(2);
        expect_out(1, 0, 1'b0, "R1 in reset");
        expect_out(1, 1, 1'b0, "R1 warn reset value");
        expect_out(1, 2, 1'b0, "R1 sec reset value");
        step(2);
        rst_n = 1'b1;
        expect_out(1, 1, 1'b1, "R4 warn after reset");
        expect_out(1, 2, 1'b1, "R6 sec after reset");

        // R2: power-up release after 150 ticks
        ticks(149);
        expect_out(1, 0, 1'b0, "R1 held before window end");
        step(1);
        ms_tick = 1'b1;
        expect_out(1, 0, 1'b1, "R2 released on 150th tick");
        step(1);
        ms_tick = 1'b0;
        step(2);

        // R6: secondary flag follows directly
        sec_low = 1'b1;
        expect_out(1, 2, 1'b0, "R6 sec fail");
        step(1);
        sec_low = 1'b0;
        expect_out(1, 2, 1'b1, "R6 sec recover");
        step(2);

        // R5: short pulse gives a warning only
        pri_low = 1'b1;
        expect_out(1, 1, 1'b0, "R4 warn on");
        expect_out(1, 0, 1'b1, "R5 short pulse k1");
        expect_out(3, 0, 1'b1, "R5 short pulse k3");
        step(3);
        pri_low = 1'b0;
        expect_out(1, 1, 1'b1, "R4 warn off");
        expect_out(3, 0, 1'b1, "R5 short pulse ignored");
        step(4);

        // R5: full brownout, reset lags warning by LEAD_CLKS
        pri_low = 1'b1;
        expect_out(1, 1, 1'b0, "R4 warn brownout");
        expect_out(4, 0, 1'b1, "R5 not yet asserted");
        expect_out(5, 0, 1'b0, "R5 asserted after lead");
        step(8);
        ticks(200);
        expect_out(1, 0, 1'b0, "R5 held during fault");
        step(1);
        pri_low = 1'b0;
        expect_out(1, 1, 1'b1, "R4 warn clears at once");
        step(2);

        // R9: fault mid-window restarts the countdown
        ticks(100);
        pri_low = 1'b1;
        step(6);
        pri_low = 1'b0;
        step(2);
        ticks(149);
        expect_out(1, 0, 1'b0, "R9 restarted window still held");
        step(1);
        ms_tick = 1'b1;
        expect_out(1, 0, 1'b1, "R9 release after full window");
        step(1);
        ms_tick = 1'b0;
        step(2);

        // R3: long window
        long_sel = 1'b1;
        pri_low = 1'b1;
        step(6);
        pri_low = 1'b0;
        step(2);
        ticks(799);
        expect_out(1, 0, 1'b0, "R3 held at 799 ticks");
        step(1);
        ms_tick = 1'b1;
        expect_out(1, 0, 1'b1, "R3 released on 800th tick");
        step(1);
        ms_tick = 1'b0;
        long_sel = 1'b0;
        step(2);

        // R7: press one tick too short is ignored
        btn_n = 1'b0;
        ticks(15);
        btn_n = 1'b1;
        expect_out(1, 0, 1'b1, "R7 short press ignored");
        step(3);
        expect_out(1, 0, 1'b1, "R7 still released");
        step(2);

        // R7: full press asserts reset
        btn_n = 1'b0;
        ticks(15);
        ms_tick = 1'b1;
        expect_out(1, 0, 1'b1, "R7 accept edge");
        expect_out(2, 0, 1'b0, "R7 reset after accept");
        step(1);
        ms_tick = 1'b0;
        step(2);
        ticks(50);
        expect_out(1, 0, 1'b0, "R7 held while pressed");
        step(1);

        // R8: release is stretched by the window
        btn_n = 1'b1;
        ticks(16);
        ticks(149);
        expect_out(1, 0, 1'b0, "R8 held 149 ticks after release");
        step(1);
        ms_tick = 1'b1;
        expect_out(1, 0, 1'b1, "R8 released after window");
        step(1);
        ms_tick = 1'b0;
        step(4);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule